// File: doc/BRIEF.md
# Swept-Strobe At-Speed Test Sequencer

This sequencer runs a delay test on a circuit that always runs on the fast rated clock, when the tester can only supply and capture data at a slower rate. Each test period is `N` rated-clock cycles long, where `N` is a programmable speed-reduction ratio. One vector is presented per period. A capture strobe for that vector is issued a programmed number of rated cycles after the vector is applied.

The whole vector set is replayed once for each strobe offset. The first pass samples one rated cycle after apply, and each later pass samples one cycle later than the one before. The final pass samples `N` cycles after apply. When the offset equals `N`, the strobe for a vector falls in the same cycle as the next vector's apply. For the last vector of that final pass, it falls in one extra cycle at the end of the test.

An external comparator reports mismatches. The sequencer samples that report only in strobe cycles. It keeps a sticky fail bit for each pass and records the first pass at which a mismatch was seen.

Top module: `strobe_sweep_seq`

## Requirements
- R1: After reset the sequencer is idle, and its outputs are low or zero: busy, done, apply, strobe, configuration error, fail mask, first-fail step and vector index.
- R2: A start pulse while idle, with a ratio N from 1 to 15 (4-bit) and a vector count V from 1 to 255, raises busy in the next cycle. The apply output then pulses in the first cycle of every N-cycle period. In pass k, period v shows vector index v (0 to V-1) and step output k.
- R3: In pass k (k from 1 to N), each strobe fires exactly k cycles after the apply of its vector. When k equals N, that strobe falls in the apply cycle of the next vector, or in one extra cycle after the last vector. No other strobes are issued.
- R4: The vector index returns to 0 at the first apply of every new pass.
- R5: A start with ratio 0 or vector count 0 leaves the sequencer idle and sets the configuration error flag. The flag clears on the next accepted start.
- R6: The comparator input is sampled only in strobe cycles. A failure in pass k sets bit k-1 of the fail mask, and the bit stays set. The first failing k is held on the first-fail output, which is 0 when no failure has occurred. Both are cleared by an accepted start.
- R7: The cycle after the last strobe of the pass with offset N, busy is low and done is high for exactly one cycle. Busy is high for N·N·V+1 cycles in total.
- R8: A start pulse while busy has no effect on the running test.
- R9: An abort drops busy in the next cycle, stops apply and strobe, and produces no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rated clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| abort_i | input | 1 | Synchronous abort |
| ratio_i | input | 4 | Speed-reduction ratio N |
| nvec_i | input | 8 | Number of vectors V |
| cmp_fail_i | input | 1 | Mismatch from the response comparator |
| vec_idx_o | output | 8 | Current vector index |
| apply_o | output | 1 | Vector apply pulse |
| strobe_o | output | 1 | Output sample strobe |
| step_o | output | 4 | Current strobe offset k |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_err_o | output | 1 | Rejected configuration |
| fail_mask_o | output | 15 | Sticky fail bit per pass |
| first_fail_step_o | output | 4 | Offset of the first failure |

## Verification
The sweep is run with ratios of 1, 2, 3, 4 and 15 and with vector counts of 1 to 3. Ratio 1 makes every strobe share a cycle with an apply. Larger ratios separate the offsets that fall inside a period from the wrap-around offset N. Single failures are placed at chosen offsets and vectors: some inside a period, some at the wrap-around point and some in the trailing cycle. This shows whether failures are credited to the right pass. Comparator noise held high outside strobe cycles shows whether the input is sampled only at strobes.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_TAIL = 2'd2
    } sq_state_e;
endpackage

// File: rtl/ssq_cfg_check.sv
module ssq_cfg_check #(
    parameter int RATIO_W = 4,
    parameter int VEC_W   = 8
) (
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [VEC_W-1:0]   nvec_i,
    output logic               cfg_ok_o
);
    always_comb begin
        cfg_ok_o = (ratio_i != '0) && (nvec_i != '0);
    end
endmodule

// File: rtl/ssq_fail_log.sv
module ssq_fail_log #(
    parameter int RATIO_W = 4,
    parameter int STEPS   = (1 << RATIO_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               strobe_i,
    input  logic               fail_i,
    input  logic [RATIO_W-1:0] step_i,
    output logic [STEPS-1:0]   mask_o,
    output logic [RATIO_W-1:0] first_o
);
    typedef struct packed {
        logic [STEPS-1:0]   mask;
        logic [RATIO_W-1:0] first;
    } log_t;

    log_t log_d, log_q;

    always_comb begin
        log_d = log_q;
        if (clear_i) begin
            log_d.mask  = '0;
            log_d.first = '0;
        end else if (strobe_i && fail_i && (step_i != '0)) begin
            log_d.mask[step_i - 1'b1] = 1'b1;
            if (log_q.first == '0) begin
                log_d.first = step_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_q <= '0;
        end else begin
            log_q <= log_d;
        end
    end

    assign mask_o  = log_q.mask;
    assign first_o = log_q.first;

    AST_FIRST_WITH_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (log_q.mask != '0) |-> (log_q.first != '0)); // R6
    AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((log_q.mask & $past(log_q.mask)) == $past(log_q.mask))); // R6
endmodule

// File: rtl/strobe_sweep_seq.sv
module strobe_sweep_seq #(
    parameter int RATIO_W = 4,
    parameter int VEC_W   = 8,
    localparam int STEPS  = (1 << RATIO_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               abort_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [VEC_W-1:0]   nvec_i,
    input  logic               cmp_fail_i,
    output logic [VEC_W-1:0]   vec_idx_o,
    output logic               apply_o,
    output logic               strobe_o,
    output logic [RATIO_W-1:0] step_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               cfg_err_o,
    output logic [STEPS-1:0]   fail_mask_o,
    output logic [RATIO_W-1:0] first_fail_step_o
);
    import ssq_pkg::*;

    typedef struct packed {
        sq_state_e          st;
        logic [RATIO_W-1:0] ratio;
        logic [VEC_W-1:0]   nvec;
        logic [RATIO_W-1:0] ph;
        logic [VEC_W-1:0]   idx;
        logic [RATIO_W-1:0] k;
        logic               cfg_err;
        logic               done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic cfg_ok;
    logic accept;
    logic last_ph, last_vec, final_pass;

    ssq_cfg_check #(.RATIO_W(RATIO_W), .VEC_W(VEC_W)) cfg_i (
        .ratio_i  (ratio_i),
        .nvec_i   (nvec_i),
        .cfg_ok_o (cfg_ok)
    );

    always_comb begin
        last_ph    = (seq_q.ph == seq_q.ratio - 1'b1);
        last_vec   = (seq_q.idx == seq_q.nvec - 1'b1);
        final_pass = (seq_q.k == seq_q.ratio);
        accept     = (seq_q.st == SQ_IDLE) && start_i && cfg_ok && !abort_i;

        seq_d      = seq_q;
        seq_d.done = 1'b0;

        unique case (seq_q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    if (cfg_ok) begin
                        seq_d.st      = SQ_RUN;
                        seq_d.ratio   = ratio_i;
                        seq_d.nvec    = nvec_i;
                        seq_d.ph      = '0;
                        seq_d.idx     = '0;
                        seq_d.k       = RATIO_W'(1);
                        seq_d.cfg_err = 1'b0;
                    end else begin
                        seq_d.cfg_err = 1'b1;
                    end
                end
            end
            SQ_RUN: begin
                if (last_ph) begin
                    seq_d.ph = '0;
                    if (last_vec) begin
                        if (final_pass) begin
                            seq_d.st = SQ_TAIL;
                        end else begin
                            seq_d.k   = seq_q.k + 1'b1;
                            seq_d.idx = '0;
                        end
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end else begin
                    seq_d.ph = seq_q.ph + 1'b1;
                end
            end
            SQ_TAIL: begin
                seq_d.st   = SQ_IDLE;
                seq_d.done = 1'b1;
                seq_d.ph   = '0;
                seq_d.idx  = '0;
                seq_d.k    = '0;
            end
            default: begin
                seq_d.st = SQ_IDLE;
            end
        endcase

        if (abort_i) begin
            seq_d.st   = SQ_IDLE;
            seq_d.ph   = '0;
            seq_d.idx  = '0;
            seq_d.k    = '0;
            seq_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: SQ_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        apply_o  = (seq_q.st == SQ_RUN) && (seq_q.ph == '0);
        strobe_o = (seq_q.st == SQ_TAIL)
                || ((seq_q.st == SQ_RUN) && !final_pass && (seq_q.ph == seq_q.k))
                || ((seq_q.st == SQ_RUN) && final_pass && (seq_q.ph == '0)
                    && (seq_q.idx != '0));
    end

    assign vec_idx_o = seq_q.idx;
    assign step_o    = seq_q.k;
    assign busy_o    = (seq_q.st != SQ_IDLE);
    assign done_o    = seq_q.done;
    assign cfg_err_o = seq_q.cfg_err;

    ssq_fail_log #(.RATIO_W(RATIO_W), .STEPS(STEPS)) log_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .strobe_i (strobe_o),
        .fail_i   (cmp_fail_i),
        .step_i   (seq_q.k),
        .mask_o   (fail_mask_o),
        .first_o  (first_fail_step_o)
    );

    AST_BAD_CFG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !abort_i && (ratio_i == '0 || nvec_i == '0))
        |=> (!busy_o && cfg_err_o)); // R5
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !done_o && !apply_o && !strobe_o)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R7
    AST_STEP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (step_o != '0)); // R3
    AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !abort_i) |=> (busy_o || done_o)); // R8
    AST_STROBE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> busy_o); // R3
endmodule

// File: tb/strobe_sweep_seq_tb_top.sv
module strobe_sweep_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        abort_i = 1'b0;
    logic [3:0]  ratio_i = '0;
    logic [7:0]  nvec_i = '0;
    logic        cmp_fail_i = 1'b0;
    logic [7:0]  vec_idx_o;
    logic        apply_o, strobe_o, busy_o, done_o, cfg_err_o;
    logic [3:0]  step_o, first_fail_step_o;
    logic [14:0] fail_mask_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    strobe_sweep_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .ratio_i(ratio_i), .nvec_i(nvec_i), .cmp_fail_i(cmp_fail_i),
        .vec_idx_o(vec_idx_o), .apply_o(apply_o), .strobe_o(strobe_o),
        .step_o(step_o), .busy_o(busy_o), .done_o(done_o), .cfg_err_o(cfg_err_o),
        .fail_mask_o(fail_mask_o), .first_fail_step_o(first_fail_step_o)
    );

    typedef struct packed {
        logic [3:0] r;
        logic [7:0] v;
        logic [3:0] fk;
        logic [7:0] fv;
        logic       noise;
    } ent_t;

    localparam int NENT = 6;
    localparam ent_t TBL [NENT] = '{
        '{4'd1,  8'd3, 4'd1,  8'd2, 1'b0},
        '{4'd2,  8'd2, 4'd2,  8'd1, 1'b1},
        '{4'd3,  8'd2, 4'd0,  8'd0, 1'b1},
        '{4'd3,  8'd2, 4'd1,  8'd1, 1'b0},
        '{4'd4,  8'd3, 4'd2,  8'd0, 1'b1},
        '{4'd15, 8'd1, 4'd15, 8'd0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_entry(input ent_t e);
        int e_apply = 0, e_idx = 0, e_r4 = 0, e_strobe = 0, e_step = 0;
        int n = int'(e.r);
        int nv = int'(e.v);
        int sv;
        bit exp_s;
        start_i = 1'b1; ratio_i = e.r; nvec_i = e.v;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
        for (int k = 1; k <= n; k++) begin
            for (int v = 0; v < nv; v++) begin
                for (int p = 0; p < n; p++) begin
                    sv = -1;
                    if (k < n && p == k) sv = v;
                    if (k == n && p == 0 && v > 0) sv = v - 1;
                    exp_s = (sv >= 0);
                    cmp_fail_i = exp_s ? (k == int'(e.fk) && sv == int'(e.fv)) : e.noise;
                    if (apply_o != (p == 0)) e_apply++;
                    if (int'(vec_idx_o) != v) e_idx++;
                    if (p == 0 && v == 0 && vec_idx_o != 8'd0) e_r4++;
                    if (strobe_o != exp_s) e_strobe++;
                    if (int'(step_o) != k) e_step++;
                    @(negedge clk);
                end
            end
        end
        cmp_fail_i = (n == int'(e.fk) && nv - 1 == int'(e.fv));
        if (strobe_o != 1'b1 || apply_o != 1'b0 || busy_o != 1'b1) e_strobe++;
        @(negedge clk);
        cmp_fail_i = 1'b0;
        chk(e_apply == 0, "R2 apply timing", e_apply, 0);
        chk(e_idx == 0, "R2 vector index", e_idx, 0);
        chk(e_r4 == 0, "R4 index reset per pass", e_r4, 0);
        chk(e_strobe == 0, "R3 strobe offset", e_strobe, 0);
        chk(e_step == 0, "R3 step output", e_step, 0);
        chk(busy_o == 1'b0 && done_o == 1'b1, "R7 done after final pass",
            {busy_o, done_o}, 1);
        chk(int'(fail_mask_o) == ((e.fk != 0) ? (1 << (int'(e.fk) - 1)) : 0),
            "R6 fail mask", int'(fail_mask_o), (e.fk != 0) ? (1 << (int'(e.fk) - 1)) : 0);
        chk(first_fail_step_o == e.fk, "R6 first fail step",
            int'(first_fail_step_o), int'(e.fk));
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done one cycle", int'(done_o), 0);
        chk(int'(fail_mask_o) == ((e.fk != 0) ? (1 << (int'(e.fk) - 1)) : 0),
            "R6 mask sticky after done", int'(fail_mask_o),
            (e.fk != 0) ? (1 << (int'(e.fk) - 1)) : 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int cnt;
        bit seen_done;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !apply_o && !strobe_o && !cfg_err_o,
            "R1 control outputs idle", {busy_o, done_o, apply_o, strobe_o, cfg_err_o}, 0);
        chk(fail_mask_o == '0 && first_fail_step_o == '0 && vec_idx_o == '0,
            "R1 log and index clear", int'(fail_mask_o), 0);

        for (int i = 0; i < NENT; i++) begin
            run_entry(TBL[i]);
        end

        // R5 ratio zero rejected
        start_i = 1'b1; ratio_i = 4'd0; nvec_i = 8'd3;
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o && cfg_err_o, "R5 ratio 0 rejected", {busy_o, cfg_err_o}, 1);
        // R5 count zero rejected
        start_i = 1'b1; ratio_i = 4'd2; nvec_i = 8'd0;
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o && cfg_err_o, "R5 count 0 rejected", {busy_o, cfg_err_o}, 1);
        chk(fail_mask_o == 15'h4000, "R5 log kept on reject", int'(fail_mask_o), 16384);
        @(negedge clk);
        chk(!apply_o && !busy_o, "R5 no activity after reject", {apply_o, busy_o}, 0);

        // R8 start while busy ignored; good start also clears R5 flag
        start_i = 1'b1; ratio_i = 4'd2; nvec_i = 8'd2;
        @(negedge clk);
        start_i = 1'b0;
        chk(!cfg_err_o && busy_o, "R5 error cleared by good start", {cfg_err_o, busy_o}, 1);
        chk(fail_mask_o == '0, "R6 log cleared by start", int'(fail_mask_o), 0);
        cnt = 1;
        seen_done = 1'b0;
        @(negedge clk);
        start_i = 1'b1; ratio_i = 4'd7; nvec_i = 8'd9;
        @(negedge clk);
        start_i = 1'b0;
        cnt += 2;
        while (busy_o && cnt < 200) begin
            chk(step_o <= 4'd2, "R8 step limited by original ratio", int'(step_o), 2);
            @(negedge clk);
            cnt++;
        end
        chk((cnt - 1) == 9, "R7 R8 busy cycle count", cnt - 1, 9);
        chk(done_o == 1'b1, "R8 done of original run", int'(done_o), 1);
        @(negedge clk);

        // R9 abort
        start_i = 1'b1; ratio_i = 4'd3; nvec_i = 8'd2;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(!busy_o && !apply_o && !strobe_o, "R9 abort to idle",
            {busy_o, apply_o, strobe_o}, 0);
        for (int j = 0; j < 30; j++) begin
            if (done_o || busy_o) seen_done = 1'b1;
            @(negedge clk);
        end
        chk(!seen_done, "R9 no done after abort", int'(seen_done), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule